// File: doc/BRIEF.md
# Interlocked Single-Word Read Link

This block joins a requesting agent and a memory agent over one set of shared lines that carry the address first and the data word afterwards. Three control wires pace the exchange: a read request, a data-valid flag and a common acknowledge. Each side changes a control wire only after it has seen the other side's previous change. Neither side therefore assumes anything about the other's speed, even though both share one clock.

A read is two complete handshakes in a row. In the first, the requester puts the address on the shared lines and the memory side acknowledges it. In the second, the memory side returns the word and the requester acknowledges it. The memory side starts its internal access at the moment it takes the address. That access runs while the first handshake is still winding down, so the second handshake starts when the later of the two has finished. Each side has a hold input that freezes its reactions, so an environment can make either side slow.

Top module: `async_read_link`

## Requirements
- R1: While reset is applied and just after it is released, read_req_o, data_rdy_o, ack_o and done_o are 0 and bus_o is all zeros.
- R2: A start_i pulse while idle places addr_i, zero-extended, on the shared lines together with read_req_o = 1. The memory side takes its address from the low AW bits of those lines and then raises the acknowledge.
- R3: read_req_o falls only in a cycle after the acknowledge was seen high. The memory side's acknowledge falls only after read_req_o was seen low.
- R4: data_rdy_o rises only when both the acknowledge and read_req_o were low. It falls only after the acknowledge was seen high. The requester's acknowledge rises only while data_rdy_o is high and falls only after data_rdy_o was seen low.
- R5: The returned word equals (address × 37 + 91) mod 2^DW. done_o is high for exactly one cycle per read, and rdata_o holds the word in that cycle.
- R6: The two sides never drive the shared lines in the same cycle. bus_o reads all zeros when neither side drives.
- R7: With no holds applied, data_rdy_o rises exactly LAT + 1 cycles after the acknowledge rises for the address. It never rises sooner than that.
- R8: The memory access overlaps the release of the address handshake. When the requester is held H cycles before dropping read_req_o, data_rdy_o rises max(LAT + 1, H + 3) cycles after the address acknowledge.
- R9: A start_i pulse while a read is in progress is ignored: no extra read, no extra done_o, and the running read returns its own word.
- R10: An asserted hold input freezes that side's reactions to the control wires but never breaks the order of the exchange. Reads under random holds on both sides return correct words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Common clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start a read (taken only while idle) |
| addr_i | input | AW | Word address of the read |
| req_hold_i | input | 1 | Freeze the requester's reactions |
| rsp_hold_i | input | 1 | Freeze the memory side's reactions |
| done_o | output | 1 | One-cycle pulse when a read completes |
| rdata_o | output | DW | Word returned by the last read |
| read_req_o | output | 1 | Read request wire |
| data_rdy_o | output | 1 | Data-valid wire |
| ack_o | output | 1 | Shared acknowledge wire |
| bus_o | output | DW | Resolved shared address/data lines |

## Verification
Reads of several addresses with no holds fix the returned words and the exact LAT + 1 cycle spacing between acknowledge and data-valid. A short hold on the requester during the address release tells an overlapped memory access from a serial one, because the spacing must stay LAT + 1. A long hold must stretch the spacing to H + 3. A second start pulse during a read shows whether a busy requester is really deaf to it. Random holds on both sides, watched by a transition monitor that checks every control-wire edge against the one before it, expose any step that fires out of order.

// File: rtl/ahs_pkg.sv
package ahs_pkg;
  localparam int unsigned WORD_MUL = 37;
  localparam int unsigned WORD_ADD = 91;

  typedef enum logic [1:0] {
    RQ_IDLE, RQ_ADDR, RQ_WAITD, RQ_ACKD
  } rq_state_t;

  typedef enum logic [2:0] {
    RS_IDLE, RS_ACKA, RS_WAITM, RS_DATA, RS_TAIL
  } rs_state_t;
endpackage

// File: rtl/ahs_requester.sv
module ahs_requester
  import ahs_pkg::*;
#(
  parameter int AW = 4,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hold_i,
  input  logic          start_i,
  input  logic [AW-1:0] addr_i,
  input  logic          ack_i,
  input  logic          data_rdy_i,
  input  logic [DW-1:0] bus_i,
  output logic          read_req_o,
  output logic          ack_o,
  output logic          drv_o,
  output logic [DW-1:0] val_o,
  output logic          done_o,
  output logic [DW-1:0] rdata_o
);
  rq_state_t     st_q, st_d;
  logic [AW-1:0] addr_q;
  logic          addr_en, cap_en, done_d;

  always_comb begin
    st_d    = st_q;
    addr_en = 1'b0;
    cap_en  = 1'b0;
    done_d  = 1'b0;
    unique case (st_q)
      RQ_IDLE:  if (start_i) begin st_d = RQ_ADDR; addr_en = 1'b1; end
      RQ_ADDR:  if (ack_i && !hold_i) st_d = RQ_WAITD;
      RQ_WAITD: if (data_rdy_i && !hold_i) begin st_d = RQ_ACKD; cap_en = 1'b1; end
      RQ_ACKD:  if (!data_rdy_i && !hold_i) begin st_d = RQ_IDLE; done_d = 1'b1; end
      default:  st_d = RQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= RQ_IDLE;
      addr_q  <= '0;
      rdata_o <= '0;
      done_o  <= 1'b0;
    end else begin
      st_q   <= st_d;
      done_o <= done_d;
      if (addr_en) addr_q  <= addr_i;
      if (cap_en)  rdata_o <= bus_i;
    end
  end

  assign read_req_o = (st_q == RQ_ADDR);
  assign drv_o      = (st_q == RQ_ADDR);
  assign val_o      = DW'(addr_q);
  assign ack_o      = (st_q == RQ_ACKD);

  assert_done_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  assert_req_drop_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(read_req_o) |-> $past(ack_i));
  assert_ack_drop_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ack_o) |-> !$past(data_rdy_i));
endmodule

// File: rtl/ahs_responder.sv
module ahs_responder
  import ahs_pkg::*;
#(
  parameter int AW  = 4,
  parameter int DW  = 16,
  parameter int LAT = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hold_i,
  input  logic          read_req_i,
  input  logic          ack_i,
  input  logic [DW-1:0] bus_i,
  output logic          ack_o,
  output logic          data_rdy_o,
  output logic          drv_o,
  output logic [DW-1:0] val_o
);
  localparam int DEPTH = 1 << AW;
  localparam int CW    = $clog2(LAT + 1);

  rs_state_t     st_q, st_d;
  logic [CW-1:0] cnt_q;
  logic [DW-1:0] word_q;
  logic [DW-1:0] mem [DEPTH];
  logic          take_en, mem_rdy;

  for (genvar g = 0; g < DEPTH; g++) begin : g_rom
    assign mem[g] = DW'(g * WORD_MUL + WORD_ADD);
  end

  assign mem_rdy = (cnt_q == '0);

  always_comb begin
    st_d    = st_q;
    take_en = 1'b0;
    unique case (st_q)
      RS_IDLE:  if (read_req_i && !hold_i) begin st_d = RS_ACKA; take_en = 1'b1; end
      RS_ACKA:  if (!read_req_i && !hold_i) st_d = RS_WAITM;
      RS_WAITM: if (mem_rdy && !ack_i && !hold_i) st_d = RS_DATA;
      RS_DATA:  if (ack_i && !hold_i) st_d = RS_TAIL;
      RS_TAIL:  if (!ack_i && !hold_i) st_d = RS_IDLE;
      default:  st_d = RS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= RS_IDLE;
      cnt_q  <= '0;
      word_q <= '0;
    end else begin
      st_q <= st_d;
      if (take_en) begin
        cnt_q  <= CW'(LAT);
        word_q <= mem[bus_i[AW-1:0]];
      end else if (!mem_rdy) begin
        cnt_q <= cnt_q - 1'b1;
      end
    end
  end

  assign ack_o      = (st_q == RS_ACKA);
  assign data_rdy_o = (st_q == RS_DATA);
  assign drv_o      = (st_q == RS_DATA);
  assign val_o      = word_q;

  assert_rdy_rise_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(data_rdy_o) |-> $past(!ack_i && !read_req_i));
  assert_rdy_fall_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(data_rdy_o) |-> $past(ack_i));
  assert_ack_fall_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ack_o) |-> !$past(read_req_i));
  assert_latency_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(data_rdy_o) |-> $past(mem_rdy));
endmodule

// File: rtl/ahs_bus_merge.sv
module ahs_bus_merge #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          a_drv_i,
  input  logic [DW-1:0] a_val_i,
  input  logic          b_drv_i,
  input  logic [DW-1:0] b_val_i,
  input  logic          a_ack_i,
  input  logic          b_ack_i,
  output logic [DW-1:0] bus_o,
  output logic          ack_o
);
  always_comb begin
    bus_o = '0;
    if (a_drv_i)      bus_o = a_val_i;
    else if (b_drv_i) bus_o = b_val_i;
  end
  assign ack_o = a_ack_i | b_ack_i;

  assert_single_driver_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(a_drv_i && b_drv_i));
endmodule

// File: rtl/async_read_link.sv
module async_read_link #(
  parameter int AW  = 4,
  parameter int DW  = 16,
  parameter int LAT = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic [AW-1:0] addr_i,
  input  logic          req_hold_i,
  input  logic          rsp_hold_i,
  output logic          done_o,
  output logic [DW-1:0] rdata_o,
  output logic          read_req_o,
  output logic          data_rdy_o,
  output logic          ack_o,
  output logic [DW-1:0] bus_o
);
  logic          rq_ack, rs_ack, rq_drv, rs_drv;
  logic [DW-1:0] rq_val, rs_val;

  ahs_requester #(.AW(AW), .DW(DW)) u_req (
    .clk(clk), .rst_n(rst_n), .hold_i(req_hold_i), .start_i(start_i),
    .addr_i(addr_i), .ack_i(ack_o), .data_rdy_i(data_rdy_o), .bus_i(bus_o),
    .read_req_o(read_req_o), .ack_o(rq_ack), .drv_o(rq_drv), .val_o(rq_val),
    .done_o(done_o), .rdata_o(rdata_o)
  );

  ahs_responder #(.AW(AW), .DW(DW), .LAT(LAT)) u_rsp (
    .clk(clk), .rst_n(rst_n), .hold_i(rsp_hold_i), .read_req_i(read_req_o),
    .ack_i(ack_o), .bus_i(bus_o), .ack_o(rs_ack), .data_rdy_o(data_rdy_o),
    .drv_o(rs_drv), .val_o(rs_val)
  );

  ahs_bus_merge #(.DW(DW)) u_merge (
    .clk(clk), .rst_n(rst_n), .a_drv_i(rq_drv), .a_val_i(rq_val),
    .b_drv_i(rs_drv), .b_val_i(rs_val), .a_ack_i(rq_ack), .b_ack_i(rs_ack),
    .bus_o(bus_o), .ack_o(ack_o)
  );

  assert_ack_rise_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ack_o) |-> $past(read_req_o || data_rdy_o));
endmodule

// File: tb/async_read_link_bench.sv
module async_read_link_bench;
  localparam int AW = 4, DW = 16, LAT = 5;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 1'b0, req_hold = 1'b0, rsp_hold = 1'b0;
  logic [AW-1:0] addr = '0;
  logic done, read_req, data_rdy, ack;
  logic [DW-1:0] rdata, bus;

  int checks = 0, errors = 0;
  int cyc = 0, ack_rise_cyc = 0, gap = 0, done_cnt = 0, viol = 0;
  bit rnd_en = 1'b0, f_req = 1'b0, f_rsp = 1'b0;
  logic p_rr = 1'b0, p_dr = 1'b0, p_ack = 1'b0;

  always #10 clk = ~clk;

  async_read_link #(.AW(AW), .DW(DW), .LAT(LAT)) u_async_read_link (
    .clk(clk), .rst_n(rst_n), .start_i(start), .addr_i(addr),
    .req_hold_i(req_hold), .rsp_hold_i(rsp_hold), .done_o(done),
    .rdata_o(rdata), .read_req_o(read_req), .data_rdy_o(data_rdy),
    .ack_o(ack), .bus_o(bus)
  );

  function automatic logic [DW-1:0] exp_word(input int a);
    return DW'(a * 37 + 91);
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  // hold drivers and interlock monitor, all at the falling edge
  always @(negedge clk) begin
    req_hold <= f_req | (rnd_en && ($urandom % 3 == 0));
    rsp_hold <= f_rsp | (rnd_en && ($urandom % 3 == 0));
    cyc++;
    if (rst_n) begin
      if (read_req && !p_rr && (p_ack || p_dr)) viol++;          // R3 request start
      if (!read_req && p_rr && !p_ack) viol++;                   // R3 request drop
      if (ack && !p_ack && !(p_rr || p_dr)) viol++;              // R4 ack rise
      if (!ack && p_ack && (p_rr || p_dr)) viol++;               // R3/R4 ack drop
      if (data_rdy && !p_dr && (p_ack || p_rr)) viol++;          // R4 rdy rise
      if (!data_rdy && p_dr && !p_ack) viol++;                   // R4 rdy drop
      if (ack && !p_ack && read_req) ack_rise_cyc = cyc;
      if (data_rdy && !p_dr) gap = cyc - ack_rise_cyc;
      if (done) done_cnt++;
    end
    p_rr = read_req; p_dr = data_rdy; p_ack = ack;
  end

  task automatic wait_done(output bit ok);
    ok = 1'b0;
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      if (done) begin ok = 1'b1; break; end
    end
  endtask

  task automatic do_read(input int a, input string req);
    bit ok;
    @(negedge clk);
    addr = AW'(a); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_done(ok);
    chk(ok, req, "done seen", ok, 1);
    chk(rdata == exp_word(a), req, "read word", rdata, exp_word(a));
    @(negedge clk);
    chk(!done, "R5", "done one cycle", done, 0);
  endtask

  task automatic t_reset;
    chk(!read_req && !data_rdy && !ack && !done, "R1", "controls in reset",
        {read_req, data_rdy, ack, done}, 0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    chk(!read_req && !data_rdy && !ack && !done, "R1", "controls after reset",
        {read_req, data_rdy, ack, done}, 0);
    chk(bus == '0, "R6", "idle bus zero", bus, 0);
  endtask

  task automatic t_plain;
    int n0 = done_cnt;
    do_read(0, "R2");
    chk(gap == LAT + 1, "R7", "unstalled latency", gap, LAT + 1);
    do_read(15, "R5");
    do_read(9, "R2");
    chk(gap == LAT + 1, "R7", "unstalled latency again", gap, LAT + 1);
    chk(bus == '0, "R6", "bus released", bus, 0);
    chk(done_cnt - n0 == 3, "R5", "done count", done_cnt - n0, 3);
  endtask

  task automatic t_hold_req(input int h, input int expg);
    bit ok;
    @(negedge clk);
    addr = AW'(6); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (!ack) @(negedge clk);
    f_req = 1'b1;
    req_hold = 1'b1;
    repeat (h) @(negedge clk);
    f_req = 1'b0;
    req_hold = 1'b0;
    wait_done(ok);
    chk(ok && rdata == exp_word(6), "R8", "word after held release", rdata, exp_word(6));
    chk(gap == expg, "R8", "overlap spacing", gap, expg);
  endtask

  task automatic t_busy_start;
    bit ok;
    int n0;
    @(negedge clk);
    n0 = done_cnt;
    addr = AW'(3); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (3) @(negedge clk);
    addr = AW'(12); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_done(ok);
    chk(rdata == exp_word(3), "R9", "busy start ignored word", rdata, exp_word(3));
    repeat (30) @(negedge clk);
    chk(done_cnt - n0 == 1, "R9", "single completion", done_cnt - n0, 1);
    chk(!read_req && !ack, "R9", "link idle", {read_req, ack}, 0);
  endtask

  task automatic t_random;
    rnd_en = 1'b1;
    for (int k = 0; k < 12; k++) do_read((k * 7 + 2) % 16, "R10");
    rnd_en = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    fork
      begin
        t_reset();
        t_plain();
        t_hold_req(2, LAT + 1);
        t_hold_req(8, 11);
        t_busy_start();
        t_random();
        chk(viol == 0, "R3", "interlock order violations", viol, 0);
        chk(viol == 0, "R4", "data handshake order", viol, 0);
      end
      begin
        repeat (100000) @(negedge clk);
        chk(1'b0, "R10", "watchdog expired", cyc, 0);
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule